// File: doc/BRIEF.md
# Warm-Reboot Boot Mode Selector

This block runs once after each configuration of the FPGA. It decides whether the device stays in its USB firmware-update loader or hands control to the user image. Two inputs drive the choice. The first is a user button. The second is a "stay in loader" marker that the user image can leave behind in an external volatile memory before it triggers a reboot.

That memory is not refreshed while the device reconfigures, so some marker bytes may decay. For this reason the marker is not a single bit. It is a run of bytes all written with one pattern value. The block reads every byte, counts how many still hold the exact pattern, and compares the count with a threshold. After judging the marker, the block wipes it, so that a later ordinary reboot boots normally.

If the block chooses the loader, it raises a loader-mode flag. Otherwise it drives an active-low reconfiguration request, which makes the device load the user image at the next boot address. While in loader mode, an arm request writes the marker and then triggers reconfiguration. Memory access uses a simple byte-wide request/acknowledge interface. The request stays high until a one-cycle acknowledge arrives, and read data is valid in that acknowledge cycle.

Top module: `boot_mode_sel`

## Requirements
- R1: During and right after reset, `boot_mode_o` is 0, `reconf_n_o` is 1 and `mem_req_o` is 0.
- R2: The button passes through a two-flop synchronizer. Its level is taken only after it has read the same value for DEB_CYC consecutive cycles (default 1000). While the button keeps bouncing, no memory access starts and no decision is made.
- R3: The marker is read as MARK_LEN bytes (default 256), in ascending order from address MARK_BASE. Only one request is outstanding at a time. While a request waits for its acknowledge, the request, address and direction are held.
- R4: A byte counts toward the marker only when it equals 0xAA exactly. A value such as 0xAB does not count.
- R5: The block picks loader mode when the sampled button is pressed (level 1) or when the match count is at least THRESH (default 128). With exactly 128 matches it picks loader mode. With 127 matches and the button released it does not.
- R6: After the read pass and before the decision, all MARK_LEN marker bytes are written with 0x00, in ascending address order.
- R7: In loader mode, `boot_mode_o` is 1 and `reconf_n_o` stays 1. This holds until an arm request is made.
- R8: When the user image is chosen, `reconf_n_o` goes low and stays low until the next reset. `boot_mode_o` stays 0.
- R9: An arm request (`arm_i` high) in loader mode drops `boot_mode_o` and writes 0xAA to all MARK_LEN marker bytes in ascending order. Only after that does `reconf_n_o` go low. The next reboot with the button released then picks loader mode.
- R10: `arm_i` is ignored in every state other than loader mode. No 0xAA byte is written, and the outcome is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted at each configuration |
| btn_i | input | 1 | Raw user button, 1 = pressed |
| arm_i | input | 1 | Request to arm the marker and reboot (loader mode only) |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_ack_i | input | 1 | One-cycle acknowledge |
| mem_rdata_i | input | 8 | Read data, valid with the acknowledge |
| boot_mode_o | output | 1 | 1 = stay in loader mode |
| reconf_n_o | output | 1 | Active-low reconfiguration request, held low |

## Verification
The assertions check, on every cycle:
- a pending request keeps its address and direction;
- the reconfiguration request never releases once low;
- loader mode and reconfiguration are never asserted together;
- loader mode is only left by starting a write;
- written data is only ever the clear or the pattern value;
- the debounced level is stable when it is declared valid;
- the match count never exceeds the marker length.

Other behaviours depend on stored memory contents and on timing across reboots, so only the bench scenarios can show them:
- the access order;
- the threshold boundary at 127 and 128 matches;
- exact-equality matching;
- suppression of decisions while the button bounces;
- arm being ignored outside loader mode;
- a full arm-then-reboot round trip.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEBOUNCE,
        ST_READ,
        ST_CLEAR,
        ST_DECIDE,
        ST_BOOT,
        ST_ARM,
        ST_RECONF
    } bsel_state_e;

    localparam logic [7:0] MARK_BYTE  = 8'hAA;
    localparam logic [7:0] CLEAR_BYTE = 8'h00;
endpackage

// File: rtl/btn_filter.sv
module btn_filter #(
    parameter int DEB_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic stable_o
);
    localparam int CW = $clog2(DEB_CYC + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          prev;
        logic [CW-1:0] cnt;
        logic          stable;
    } flt_t;

    flt_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.s1   = raw_i;
        r_d.s2   = r_q.s1;
        r_d.prev = r_q.s2;
        if (r_q.s2 != r_q.prev) begin
            r_d.cnt    = '0;
            r_d.stable = 1'b0;
        end else if (r_q.cnt < CW'(DEB_CYC - 1)) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end else begin
            r_d.stable = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign level_o  = r_q.prev;
    assign stable_o = r_q.stable;

    // R2: stability is only declared when the synchronized level did not move
    p_stable_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stable_o) |-> $stable(level_o));
endmodule

// File: rtl/mark_tally.sv
module mark_tally #(
    parameter int MARK_LEN = 256
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr_i,
    input  logic                           hit_i,
    output logic [$clog2(MARK_LEN+1)-1:0]  count_o
);
    localparam int CNT_W = $clog2(MARK_LEN + 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (hit_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    // R4: the tally can never exceed the number of marker bytes
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MARK_LEN));
endmodule

// File: rtl/boot_mode_sel.sv
module boot_mode_sel
    import boot_sel_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MARK_BASE = 0,
    parameter int MARK_LEN  = 256,
    parameter int THRESH    = 128,
    parameter int DEB_CYC   = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btn_i,
    input  logic              arm_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [7:0]        mem_rdata_i,
    output logic              boot_mode_o,
    output logic              reconf_n_o
);
    localparam int IDX_W = (MARK_LEN > 1) ? $clog2(MARK_LEN) : 1;
    localparam int CNT_W = $clog2(MARK_LEN + 1);

    typedef struct packed {
        bsel_state_e      st;
        logic [IDX_W-1:0] idx;
        logic             btn;
    } ctl_t;

    ctl_t c_q, c_d;

    logic             flt_level, flt_stable;
    logic [CNT_W-1:0] match_cnt;
    logic             last_idx;
    logic             hit;

    btn_filter #(.DEB_CYC(DEB_CYC)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (btn_i),
        .level_o  (flt_level),
        .stable_o (flt_stable)
    );

    assign hit = (c_q.st == ST_READ) && mem_ack_i && (mem_rdata_i == MARK_BYTE);

    mark_tally #(.MARK_LEN(MARK_LEN)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (c_q.st == ST_IDLE),
        .hit_i   (hit),
        .count_o (match_cnt)
    );

    assign last_idx = (c_q.idx == IDX_W'(MARK_LEN - 1));

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE:     c_d.st = ST_DEBOUNCE;
            ST_DEBOUNCE: if (flt_stable) begin
                             c_d.btn = flt_level;
                             c_d.idx = '0;
                             c_d.st  = ST_READ;
                         end
            ST_READ, ST_CLEAR, ST_ARM: if (mem_ack_i) begin
                             c_d.idx = c_q.idx + 1'b1;
                             if (last_idx) begin
                                 c_d.idx = '0;
                                 c_d.st  = (c_q.st == ST_READ)  ? ST_CLEAR  :
                                           (c_q.st == ST_CLEAR) ? ST_DECIDE : ST_RECONF;
                             end
                         end
            ST_DECIDE:   c_d.st = (c_q.btn || (match_cnt >= CNT_W'(THRESH))) ? ST_BOOT : ST_RECONF;
            ST_BOOT:     if (arm_i) begin
                             c_d.idx = '0;
                             c_d.st  = ST_ARM;
                         end
            default:     c_d.st = ST_RECONF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, idx: '0, btn: 1'b0};
        else        c_q <= c_d;
    end

    assign mem_req_o   = (c_q.st == ST_READ) || (c_q.st == ST_CLEAR) || (c_q.st == ST_ARM);
    assign mem_we_o    = (c_q.st == ST_CLEAR) || (c_q.st == ST_ARM);
    assign mem_wdata_o = (c_q.st == ST_ARM) ? MARK_BYTE : CLEAR_BYTE;
    assign mem_addr_o  = ADDR_W'(MARK_BASE) + ADDR_W'(c_q.idx);
    assign boot_mode_o = (c_q.st == ST_BOOT);
    assign reconf_n_o  = (c_q.st != ST_RECONF);

    // R3: a pending request keeps its address and direction
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
    // R8: reconfiguration request is sticky
    p_reconf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reconf_n_o |=> !reconf_n_o);
    // R7: loader mode and reconfiguration are exclusive
    p_mode_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(boot_mode_o && !reconf_n_o));
    // R9: loader mode is left only by starting the marker write
    p_boot_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(boot_mode_o) |-> (mem_req_o && mem_we_o && mem_wdata_o == MARK_BYTE));
    // R6: written data is either the clear value or the pattern
    p_wdata_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> (mem_wdata_o == CLEAR_BYTE || mem_wdata_o == MARK_BYTE));
endmodule

// File: tb/boot_mode_sel_tb_top.sv
module boot_mode_sel_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEN  = 256;
    localparam int BASE = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        btn = 1'b0;
    logic        arm = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        boot_mode, reconf_n;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // memory model state
    logic [7:0] mem [LEN];
    logic       load_en = 1'b0;
    int         load_aa = 0;
    logic [7:0] load_fill = 8'h00;
    int         seq;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_mode_sel #(.ADDR_W(16), .MARK_BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .btn_i(btn), .arm_i(arm),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .boot_mode_o(boot_mode), .reconf_n_o(reconf_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference memory: acknowledges one cycle after a request; checks each access
    // against the expected sequence (R3 reads, R6 clears, R9 arm writes).
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            seq     <= 0;
            if (load_en)
                for (int i = 0; i < LEN; i++) mem[i] <= (i < load_aa) ? 8'hAA : load_fill;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            mem_ack <= 1'b1;
            if (seq < LEN) begin
                chk(!mem_we && mem_addr == 16'(BASE + seq), "R3 read order", mem_addr, BASE + seq);
            end else if (seq < 2*LEN) begin
                chk(mem_we && mem_wdata == 8'h00 && mem_addr == 16'(BASE + seq - LEN),
                    "R6 clear order", {mem_wdata, mem_addr}, BASE + seq - LEN);
            end else begin
                chk(mem_we && mem_wdata == 8'hAA && mem_addr == 16'(BASE + seq - 2*LEN),
                    "R9 arm order", {mem_wdata, mem_addr}, BASE + seq - 2*LEN);
            end
            if (mem_we) mem[mem_addr - 16'(BASE)] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr - 16'(BASE)];
            seq <= seq + 1;
        end
    end

    function automatic int count_val(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < LEN; i++) if (mem[i] == v) n++;
        return n;
    endfunction

    task automatic reboot(input logic load, input int n_aa, input logic [7:0] fill, input logic b);
        @(negedge clk);
        rst_n     = 1'b0;
        load_en   = load;
        load_aa   = n_aa;
        load_fill = fill;
        btn       = b;
        repeat (3) @(negedge clk);
        load_en = 1'b0;
        chk(!boot_mode && reconf_n && !mem_req, "R1 reset state", {boot_mode, reconf_n, mem_req}, 3'b010);
        rst_n = 1'b1;
    endtask

    task automatic wait_end();
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (boot_mode || !reconf_n) break;
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic expect_boot(input string req);
        chk(boot_mode && reconf_n, req, {boot_mode, reconf_n}, 2'b11);
    endtask

    task automatic expect_user(input string req);
        chk(!boot_mode && !reconf_n, req, {boot_mode, reconf_n}, 2'b00);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R5: button pressed, marker absent -> loader; R6 wipes marker
        reboot(1'b1, 0, 8'h00, 1'b1);
        wait_end();
        expect_boot("R5 button forces loader");
        chk(count_val(8'h00) == LEN, "R6 marker wiped", count_val(8'h00), LEN);
        repeat (50) @(negedge clk);
        expect_boot("R7 loader mode held");
        chk(seq == 2*LEN, "R7 no extra access", seq, 2*LEN);

        // R8: nothing present -> user image, sticky low
        reboot(1'b1, 0, 8'h00, 1'b0);
        wait_end();
        expect_user("R8 user image chosen");
        repeat (100) @(negedge clk);
        expect_user("R8 reconf held low");

        // R5 boundary: exactly 128 matches
        reboot(1'b1, 128, 8'h55, 1'b0);
        wait_end();
        expect_boot("R5 threshold 128 met");
        chk(count_val(8'h00) == LEN, "R6 marker wiped after judge", count_val(8'h00), LEN);

        // R5 boundary: 127 matches
        reboot(1'b1, 127, 8'h55, 1'b0);
        wait_end();
        expect_user("R5 127 below threshold");

        // R4: near-miss bytes never match
        reboot(1'b1, 0, 8'hAB, 1'b0);
        wait_end();
        expect_user("R4 0xAB not a match");

        // R4: full marker of 0xAA matches
        reboot(1'b1, 256, 8'h00, 1'b0);
        wait_end();
        expect_boot("R4 full marker");

        // R9: arm from loader mode, then warm reboot returns to loader
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        chk(!boot_mode, "R9 loader left on arm", boot_mode, 0);
        chk(reconf_n, "R9 reconf waits for writes", reconf_n, 1);
        wait_end();
        expect_user("R9 reconf after arm");
        chk(count_val(8'hAA) == LEN, "R9 marker written", count_val(8'hAA), LEN);
        reboot(1'b0, 0, 8'h00, 1'b0);
        wait_end();
        expect_boot("R9 armed reboot enters loader");

        // R10: arm outside loader mode ignored
        reboot(1'b1, 0, 8'h00, 1'b0);
        arm = 1'b1;
        wait_end();
        arm = 1'b0;
        expect_user("R10 arm ignored outcome");
        chk(seq == 2*LEN, "R10 no arm writes", seq, 2*LEN);
        chk(count_val(8'hAA) == 0, "R10 no pattern in memory", count_val(8'hAA), 0);

        // R2: bouncing button delays the decision
        reboot(1'b1, 0, 8'h00, 1'b0);
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (k % 7 == 0) btn = ~btn;
        end
        chk(!mem_req && !boot_mode && reconf_n, "R2 no decision while bouncing",
            {mem_req, boot_mode, reconf_n}, 3'b001);
        btn = 1'b1;
        wait_end();
        expect_boot("R2 settled press sampled");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule